// File: doc/BRIEF.md
# Instrument Bus Direction Steering Glue

This block sits between the general-purpose port of a small bus controller and an eight-bit instrument bus whose control lines are open-drain and active-low (ATN, SRQ, IFC, REN, EOI, DAV, NRFD, NDAC). The controller writes a six-bit mode register that tells the glue whether it currently owns the bus and whether it has been addressed as a talker. A strap says whether the card is the system controller.

From the mode register, the strap, the controller's port levels and the synchronized bus lines, the block decides four things:
- which side drives each control line;
- when the controller's data byte is allowed onto the bus;
- what the controller sees when it reads its port back;
- whether the controller's interrupt request is raised.

Every output is registered once per clock from synchronized bus inputs. This breaks the loop that would otherwise form through ATN and EOI.

A released line is driven as 1, so that the bus wire is the AND of all drivers. Port control bits use this order: bit 7 IFC, bit 6 REN, bit 5 SRQ, bit 4 ATN, bit 3 EOI, bit 2 DAV, bit 1 NDAC, bit 0 NRFD. The bus control vectors (`bus_ctl_i`, `bus_ctl_o`) use the same order. Mode register bits are: bit 5 owns-bus (controller active), bit 4 addressed-talker, bit 3 IFC interrupt enable, bit 2 REN interrupt enable, bit 1 ATN interrupt enable, bit 0 NDAC hold enable.

Top module: `gpib_dir_steer`

## Requirements
- R1: After reset every control output and every data output is released (all ones), the interrupt is low and the mode register holds zero.
- R2: A write strobe loads the mode register. Its bits take effect on the outputs one clock after the write, and with all enables clear no interrupt is raised.
- R3: With owns-bus (mode bit 5) set, port ATN (bit 4) drives bus ATN and bus SRQ (bit 5) is released. The internal ATN is then the port ATN. With owns-bus clear, bus ATN is released, port SRQ drives bus SRQ, and the internal ATN is port ATN AND bus ATN.
- R4: Talk direction is selected when (owns-bus AND internal ATN high) OR (addressed-talker, mode bit 4, AND internal ATN low).
- R5: When talking, port DAV (bit 2) and EOI (bit 3) drive the bus and NRFD and NDAC are released. When listening, port NRFD (bit 0) drives the bus and DAV and EOI are released. In that case port NDAC (bit 1) drives the bus, except that it is forced low when NDAC hold (mode bit 0) is set and internal ATN is high.
- R6: With the system-controller strap on, port REN (bit 6) and IFC (bit 7) drive the bus and the internal REN is port REN. With the strap off, both lines are released and the internal REN is port REN AND bus REN.
- R7: The port data byte is placed on the bus only when talking and (internal ATN low or bus EOI high). Otherwise the bus data output is all ones. The data read-back returns all ones while the block drives and returns the bus byte otherwise.
- R8: The interrupt is (mode bit 3 AND bus IFC low) OR (mode bit 2 AND internal REN high) OR (mode bit 1 AND internal ATN low).
- R9: Port read-back places each line at its port bit position:
  - IFC and REN read 1 with the strap on and read the bus lines with it off.
  - SRQ reads 0 only when owns-bus is set and bus SRQ is low.
  - ATN reads the internal ATN.
  - When talking, EOI and DAV read 1, NRFD reads the bus, and NDAC reads the bus AND (hold disabled OR internal ATN high).
  - When listening, EOI and DAV read the bus, NRFD reads 1, and NDAC reads (hold disabled OR internal ATN high).
- R10: The switch read-back holds the bus address strap in bits 4..0 and the system-controller strap in bit 5, with bits 7..6 at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 6 | Mode register write value |
| port_ctl | input | 8 | Controller control-port levels, active-low |
| port_data | input | DATA_W | Controller data byte |
| sys_ctrl_strap | input | 1 | System-controller strap |
| bus_addr_strap | input | ADDR_W | Bus address strap |
| bus_ctl_i | input | 8 | Bus control line levels as seen on the wire |
| bus_data_i | input | DATA_W | Bus data lines as seen on the wire |
| bus_ctl_o | output | 8 | Control line drive, 1 = released |
| bus_data_o | output | DATA_W | Data line drive, all ones = released |
| port_ctl_rd | output | 8 | Control-port read-back value |
| port_data_rd | output | DATA_W | Data-port read-back value |
| switch_rd | output | 8 | Strap read-back value |
| ctrl_irq | output | 1 | Controller interrupt request |

## Verification
The assertions assume that the mode register and the straps change only on clock edges. They also assume that the bus inputs are the wired-AND of the block's own drive with the other devices, so the wire can never be high while the block drives it low. The bench feeds the bus inputs from exactly such a wired-AND model. It changes the port, mode and external bus levels only between edges, then lets the synchronizers and the output register settle before it samples.

// File: rtl/gds_pkg.sv
package gds_pkg;
    // control line positions, shared by port and bus vectors
    localparam int CTL_W    = 8;
    localparam int L_IFC    = 7;
    localparam int L_REN    = 6;
    localparam int L_SRQ    = 5;
    localparam int L_ATN    = 4;
    localparam int L_EOI    = 3;
    localparam int L_DAV    = 2;
    localparam int L_NDAC   = 1;
    localparam int L_NRFD   = 0;

    // mode register positions
    localparam int MODE_W   = 6;
    localparam int M_OWN    = 5;
    localparam int M_TALK   = 4;
    localparam int M_IFCIE  = 3;
    localparam int M_RENIE  = 2;
    localparam int M_ATNIE  = 1;
    localparam int M_HOLD   = 0;

    localparam int SWR_W    = 8;
endpackage

// File: rtl/gds_sync.sv
module gds_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= '1;
                    else        stg_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= '1;
                    else        stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gds_mode_reg.sv
module gds_mode_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (we) mode_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    assign q = mode_q;
endmodule

// File: rtl/gpib_dir_steer.sv
module gpib_dir_steer
    import gds_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [5:0]        mode_wdata,
    input  logic [7:0]        port_ctl,
    input  logic [DATA_W-1:0] port_data,
    input  logic              sys_ctrl_strap,
    input  logic [ADDR_W-1:0] bus_addr_strap,
    input  logic [7:0]        bus_ctl_i,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic [7:0]        bus_ctl_o,
    output logic [DATA_W-1:0] bus_data_o,
    output logic [7:0]        port_ctl_rd,
    output logic [DATA_W-1:0] port_data_rd,
    output logic [7:0]        switch_rd,
    output logic              ctrl_irq
);
    localparam int SW_PAD = SWR_W - ADDR_W - 1;

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [DATA_W-1:0] data;
        logic [CTL_W-1:0]  prd;
        logic [DATA_W-1:0] drd;
        logic [SWR_W-1:0]  swr;
        logic              irq;
    } steer_t;

    localparam steer_t ST_RESET = '{ctl: '1, data: '1, prd: '1, drd: '1, swr: '1, irq: 1'b0};

    logic [MODE_W-1:0] mode_q;
    logic [CTL_W-1:0]  bctl_s;
    logic [DATA_W-1:0] bdat_s;
    steer_t            st_d, st_q;

    logic own_bus, atn_int, ren_int, talk, drive, ndac_ok;

    gds_mode_reg #(.W(MODE_W)) i_mode (
        .clk(clk), .rst_n(rst_n), .we(mode_we), .wdata(mode_wdata), .q(mode_q)
    );

    gds_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) i_sync_ctl (
        .clk(clk), .rst_n(rst_n), .d(bus_ctl_i), .q(bctl_s)
    );

    gds_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) i_sync_dat (
        .clk(clk), .rst_n(rst_n), .d(bus_data_i), .q(bdat_s)
    );

    always_comb begin
        st_d    = st_q;
        own_bus = mode_q[M_OWN];

        // ATN and SRQ ownership
        if (own_bus) begin
            atn_int         = port_ctl[L_ATN];
            st_d.ctl[L_ATN] = port_ctl[L_ATN];
            st_d.ctl[L_SRQ] = 1'b1;
        end else begin
            atn_int         = port_ctl[L_ATN] & bctl_s[L_ATN];
            st_d.ctl[L_ATN] = 1'b1;
            st_d.ctl[L_SRQ] = port_ctl[L_SRQ];
        end

        talk    = (own_bus & atn_int) | (mode_q[M_TALK] & ~atn_int);
        ndac_ok = ~mode_q[M_HOLD] | atn_int;

        // handshake direction
        if (talk) begin
            st_d.ctl[L_DAV]  = port_ctl[L_DAV];
            st_d.ctl[L_EOI]  = port_ctl[L_EOI];
            st_d.ctl[L_NRFD] = 1'b1;
            st_d.ctl[L_NDAC] = 1'b1;
        end else begin
            st_d.ctl[L_DAV]  = 1'b1;
            st_d.ctl[L_EOI]  = 1'b1;
            st_d.ctl[L_NRFD] = port_ctl[L_NRFD];
            st_d.ctl[L_NDAC] = port_ctl[L_NDAC] & ~(mode_q[M_HOLD] & atn_int);
        end

        // system controller lines
        if (sys_ctrl_strap) begin
            st_d.ctl[L_REN] = port_ctl[L_REN];
            st_d.ctl[L_IFC] = port_ctl[L_IFC];
            ren_int         = port_ctl[L_REN];
        end else begin
            st_d.ctl[L_REN] = 1'b1;
            st_d.ctl[L_IFC] = 1'b1;
            ren_int         = port_ctl[L_REN] & bctl_s[L_REN];
        end

        // data drivers
        drive     = talk & (~atn_int | bctl_s[L_EOI]);
        st_d.data = drive ? port_data : '1;
        st_d.drd  = drive ? '1 : bdat_s;

        // port read-back
        st_d.prd[L_IFC] = sys_ctrl_strap | bctl_s[L_IFC];
        st_d.prd[L_REN] = sys_ctrl_strap | bctl_s[L_REN];
        st_d.prd[L_SRQ] = ~own_bus | bctl_s[L_SRQ];
        st_d.prd[L_ATN] = atn_int;
        if (talk) begin
            st_d.prd[L_EOI]  = 1'b1;
            st_d.prd[L_DAV]  = 1'b1;
            st_d.prd[L_NDAC] = ndac_ok & bctl_s[L_NDAC];
            st_d.prd[L_NRFD] = bctl_s[L_NRFD];
        end else begin
            st_d.prd[L_EOI]  = bctl_s[L_EOI];
            st_d.prd[L_DAV]  = bctl_s[L_DAV];
            st_d.prd[L_NDAC] = ndac_ok;
            st_d.prd[L_NRFD] = 1'b1;
        end

        st_d.swr = {{SW_PAD{1'b1}}, sys_ctrl_strap, bus_addr_strap};

        st_d.irq = (mode_q[M_IFCIE] & ~bctl_s[L_IFC]) |
                   (mode_q[M_RENIE] & ren_int) |
                   (mode_q[M_ATNIE] & ~atn_int);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign bus_ctl_o    = st_q.ctl;
    assign bus_data_o   = st_q.data;
    assign port_ctl_rd  = st_q.prd;
    assign port_data_rd = st_q.drd;
    assign switch_rd    = st_q.swr;
    assign ctrl_irq     = st_q.irq;
endmodule

// File: rtl/gds_checker.sv
module gds_checker
    import gds_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode_q,
    input logic              sys_ctrl_strap,
    input logic [7:0]        bus_ctl_o,
    input logic [DATA_W-1:0] bus_data_o,
    input logic [DATA_W-1:0] port_data_rd,
    input logic              ctrl_irq
);
    assert_own_srq_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[M_OWN] |=> bus_ctl_o[L_SRQ]);

    assert_atn_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[M_OWN] |=> bus_ctl_o[L_ATN]);

    assert_dir_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ctl_o[L_DAV] |-> (bus_ctl_o[L_NRFD] && bus_ctl_o[L_NDAC]));

    assert_no_strap_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_ctrl_strap |=> (bus_ctl_o[L_IFC] && bus_ctl_o[L_REN]));

    assert_drive_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_data_o != '1) |-> (port_data_rd == '1));

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[M_IFCIE:M_ATNIE] == 3'b000) |=> !ctrl_irq);
endmodule

bind gpib_dir_steer gds_checker #(.DATA_W(DATA_W)) i_gds_checker (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .sys_ctrl_strap(sys_ctrl_strap),
    .bus_ctl_o(bus_ctl_o), .bus_data_o(bus_data_o),
    .port_data_rd(port_data_rd), .ctrl_irq(ctrl_irq)
);

// File: tb/test_gpib_dir_steer.sv
module test_gpib_dir_steer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0;
    logic [5:0] mode_wdata = '0;
    logic [7:0] port_ctl = 8'hFF;
    logic [7:0] port_data = 8'hFF;
    logic       sys_ctrl_strap = 1'b0;
    logic [4:0] bus_addr_strap = '0;
    logic [7:0] ext_ctl = 8'hFF;
    logic [7:0] ext_data = 8'hFF;
    logic [7:0] bus_ctl_i, bus_data_i, bus_ctl_o, bus_data_o;
    logic [7:0] port_ctl_rd, port_data_rd, switch_rd;
    logic       ctrl_irq;
    int         total = 0;
    int         fails = 0;

    always #2 clk = ~clk;

    // wired-AND bus model
    assign bus_ctl_i  = bus_ctl_o & ext_ctl;
    assign bus_data_i = bus_data_o & ext_data;

    gpib_dir_steer i_gpib_dir_steer (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .port_ctl(port_ctl), .port_data(port_data), .sys_ctrl_strap(sys_ctrl_strap),
        .bus_addr_strap(bus_addr_strap), .bus_ctl_i(bus_ctl_i), .bus_data_i(bus_data_i),
        .bus_ctl_o(bus_ctl_o), .bus_data_o(bus_data_o), .port_ctl_rd(port_ctl_rd),
        .port_data_rd(port_data_rd), .switch_rd(switch_rd), .ctrl_irq(ctrl_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic set_mode(input logic [5:0] v);
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = v;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ctl", bus_ctl_o, 8'hFF);
        chk("R1 data", bus_data_o, 8'hFF);
        chk("R1 irq", ctrl_irq, 0);
        chk("R1 ndac no hold", bus_ctl_o[1], 1);
    endtask

    task automatic t_owner();
        set_mode(6'h20);
        // delay of one clock after the write
        port_ctl = 8'hEF;
        @(negedge clk);
        chk("R2 atn one clock", bus_ctl_o[4], 0);
        settle();
        chk("R3 atn driven", bus_ctl_o[4], 0);
        chk("R3 srq free", bus_ctl_o[5], 1);
        chk("R4 listen under atn", bus_ctl_o[2], 1);
        port_ctl = 8'hFB; settle();
        chk("R4 talk dav", bus_ctl_o[2], 0);
        chk("R5 nrfd free", bus_ctl_o[0], 1);
        chk("R5 ndac free", bus_ctl_o[1], 1);
    endtask

    task automatic t_data();
        port_ctl = 8'hFF; port_data = 8'h5A; ext_data = 8'hFF; settle();
        chk("R7 driven", bus_data_o, 8'h5A);
        chk("R7 rd ff", port_data_rd, 8'hFF);
        port_ctl = 8'hF7; ext_data = 8'h3C; settle();
        chk("R7 eoi gates", bus_data_o, 8'hFF);
        chk("R7 rd bus", port_data_rd, 8'h3C);
        chk("R5 eoi follows", bus_ctl_o[3], 0);
        ext_data = 8'hFF;
    endtask

    task automatic t_talker();
        set_mode(6'h10);
        port_ctl = 8'hFF; ext_ctl = 8'hEF; port_data = 8'hA5; settle();
        chk("R3 atn released", bus_ctl_o[4], 1);
        chk("R4 talker under atn", bus_data_o, 8'hA5);
        chk("R9 atn read", port_ctl_rd[4], 0);
        ext_ctl = 8'hFF; settle();
        chk("R4 listen no atn", bus_data_o, 8'hFF);
        port_ctl = 8'hDF; settle();
        chk("R3 srq driven", bus_ctl_o[5], 0);
        port_ctl = 8'hFF;
    endtask

    task automatic t_hold();
        set_mode(6'h01); settle();
        chk("R5 hold low", bus_ctl_o[1], 0);
        chk("R9 ndac rd hold", port_ctl_rd[1], 1);
        ext_ctl = 8'hEF; settle();
        chk("R5 hold off under atn", bus_ctl_o[1], 1);
        port_ctl = 8'hFD; settle();
        chk("R5 ndac follows", bus_ctl_o[1], 0);
        port_ctl = 8'hFF; ext_ctl = 8'hFF;
    endtask

    task automatic t_strap();
        set_mode(6'h00);
        sys_ctrl_strap = 1'b1; port_ctl = 8'h3F; settle();
        chk("R6 ren driven", bus_ctl_o[6], 0);
        chk("R6 ifc driven", bus_ctl_o[7], 0);
        sys_ctrl_strap = 1'b0; settle();
        chk("R6 ren free", bus_ctl_o[6], 1);
        chk("R6 ifc free", bus_ctl_o[7], 1);
        port_ctl = 8'hFF;
    endtask

    task automatic t_irq();
        set_mode(6'h04); settle();
        chk("R8 ren irq", ctrl_irq, 1);
        ext_ctl = 8'hBF; settle();
        chk("R8 ren low no irq", ctrl_irq, 0);
        ext_ctl = 8'h7F; set_mode(6'h08); settle();
        chk("R8 ifc irq", ctrl_irq, 1);
        set_mode(6'h00); settle();
        chk("R2 masked", ctrl_irq, 0);
        ext_ctl = 8'hEF; set_mode(6'h02); settle();
        chk("R8 atn irq", ctrl_irq, 1);
        ext_ctl = 8'hFF; set_mode(6'h00); settle();
    endtask

    task automatic t_readback();
        ext_ctl = 8'hF3; settle();
        chk("R9 listener rd", port_ctl_rd, 8'hF3);
        set_mode(6'h20); ext_ctl = 8'hFE; settle();
        chk("R9 talker rd", port_ctl_rd, 8'hFE);
        ext_ctl = 8'hDE; settle();
        chk("R9 srq rd", port_ctl_rd, 8'hDE);
        ext_ctl = 8'hFF; set_mode(6'h00);
    endtask

    task automatic t_switch();
        sys_ctrl_strap = 1'b1; bus_addr_strap = 5'h15; settle();
        chk("R10 switch a", switch_rd, 8'hF5);
        sys_ctrl_strap = 1'b0; bus_addr_strap = 5'h0A; settle();
        chk("R10 switch b", switch_rd, 8'hCA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_owner();
        t_data();
        t_talker();
        t_hold();
        t_strap();
        t_irq();
        t_readback();
        t_switch();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule